// File: doc/BRIEF.md
# Multicycle Microstate Control Sequencer

This block is the control unit of a single-bus processor datapath. It is a finite-state machine that steps through a fixed series of microstates for each instruction. In every clock cycle it emits one control word. The word holds five bus drive enables, six load enables, a register write enable, a memory write enable, a two-bit register selector and a two-bit ALU function.

Each instruction starts with a three-cycle fetch and a one-cycle decode. The decode cycle reads the four opcode bits taken from the top of the instruction register. After decode, the sequencer runs the execute microstates for that opcode and returns to the first fetch microstate. The halt opcode is the exception: it parks the machine in an idle state until reset.

A branch-equal instruction loads the zero flag in one cycle and tests the flag's value in the next. The zero flag arrives back from the datapath on `zero_i`.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst_ni` is low, every output is 0. In the first cycle after release, the block emits the first fetch word.
- R2: Fetch takes three cycles and the block emits the following words.
  - Cycle 1: `dr_pc_o`, `ld_mar_o`, `ld_a_o`.
  - Cycle 2: `dr_mem_o`, `ld_ir_o`.
  - Cycle 3: `dr_alu_o`, `ld_pc_o`, with `alu_func_o`=3. The ALU function codes are 0 add, 1 nand, 2 subtract, 3 increment A.
- R3: The fourth cycle is decode. It emits an all-zero word and dispatches on `opcode_i`. The opcode codes are add 0, nand 1, addi 2, lw 3, sw 4, beq 5, jalr 6, halt 7.
- R4: Add and nand each take three cycles and the block emits the following words. The register selector codes are 0 destination, 1 first source, 2 second source.
  - Cycle 1: `dr_reg_o` and `ld_a_o`, with `reg_sel_o`=1.
  - Cycle 2: `dr_reg_o` and `ld_b_o`, with `reg_sel_o`=2.
  - Cycle 3: `dr_alu_o` and `wr_reg_o`, with `reg_sel_o`=0. `alu_func_o` is 0 for add and 1 for nand.
- R5: Addi takes three cycles and the block emits the following words.
  - Cycle 1: the same as add cycle 1.
  - Cycle 2: `dr_off_o` and `ld_b_o`.
  - Cycle 3: `dr_alu_o` and `wr_reg_o`, with `reg_sel_o`=0 and `alu_func_o`=0.
- R6: Lw takes four cycles and the block emits the following words.
  - Cycles 1 and 2: the same as addi cycles 1 and 2.
  - Cycle 3: `dr_alu_o` and `ld_mar_o`, with `alu_func_o`=0.
  - Cycle 4: `dr_mem_o` and `wr_reg_o`, with `reg_sel_o`=0.
- R7: Sw takes four cycles. Cycles 1 to 3 are the same as lw. Cycle 4 emits `dr_reg_o` and `wr_mem_o`, with `reg_sel_o`=0.
- R8: Beq emits the following words.
  - Cycles 1 and 2: the same as add cycles 1 and 2.
  - Cycle 3: `dr_alu_o` and `ld_z_o`, with `alu_func_o`=2.
  - Cycle 4: an all-zero word that samples `zero_i`.
  - If `zero_i` is 1, three more cycles follow: cycle 5 `dr_pc_o` and `ld_a_o`; cycle 6 `dr_off_o` and `ld_b_o`; cycle 7 `dr_alu_o` and `ld_pc_o`, with `alu_func_o`=0.
  - If `zero_i` is 0, fetch follows cycle 4.
- R9: Jalr takes two cycles and the block emits the following words.
  - Cycle 1: `dr_pc_o` and `wr_reg_o`, with `reg_sel_o`=1.
  - Cycle 2: `dr_reg_o` and `ld_pc_o`, with `reg_sel_o`=0.
- R10: After decoding halt, the block emits all-zero words in every cycle until reset.
- R11: Opcodes 8 to 15 go straight from decode back to fetch cycle 1.
- R12: At most one bus drive enable is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 4 | Opcode field of the instruction register |
| zero_i | input | 1 | Zero flag from the datapath |
| dr_pc_o | output | 1 | Drive PC onto bus |
| dr_alu_o | output | 1 | Drive ALU result onto bus |
| dr_reg_o | output | 1 | Drive selected register onto bus |
| dr_mem_o | output | 1 | Drive memory data onto bus |
| dr_off_o | output | 1 | Drive sign-extended offset onto bus |
| ld_pc_o | output | 1 | Load PC from bus |
| ld_ir_o | output | 1 | Load instruction register |
| ld_mar_o | output | 1 | Load memory address register |
| ld_a_o | output | 1 | Load ALU operand A |
| ld_b_o | output | 1 | Load ALU operand B |
| ld_z_o | output | 1 | Load zero flag |
| wr_reg_o | output | 1 | Write selected register |
| wr_mem_o | output | 1 | Write memory |
| reg_sel_o | output | 2 | Register selector |
| alu_func_o | output | 2 | ALU function |

## Verification
The bench targets the following corner cases.

- Beq with the zero flag both set and clear. A design that samples the flag in the same cycle it is loaded would branch on stale data. A design that ignores the flag would take the branch every time, or never.
- Halt followed by a reset. A halt state that falls through to fetch would emit a fetch word where zeros are expected.
- Undefined opcodes. An unguarded dispatch would enter some execute sequence instead of returning to fetch.
- Every word, every cycle. Each word is compared in full, so a swapped register selector or ALU code shows up in the exact microstate where it occurs.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OPC_W  = 4;
  localparam int SEL_W  = 2;
  localparam int FUNC_W = 2;
  localparam int ST_W   = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'd0, OP_NAND = 4'd1, OP_ADDI = 4'd2, OP_LW = 4'd3,
    OP_SW  = 4'd4, OP_BEQ  = 4'd5, OP_JALR = 4'd6, OP_HALT = 4'd7
  } opc_e;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD = 2'd0, FN_NAND = 2'd1, FN_SUB = 2'd2, FN_INC = 2'd3
  } func_e;

  localparam logic [SEL_W-1:0] SEL_DST = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SR1 = 2'd1;
  localparam logic [SEL_W-1:0] SEL_SR2 = 2'd2;

  typedef enum logic [ST_W-1:0] {
    S_F1, S_F2, S_F3, S_DEC,
    S_ADD1, S_ADD2, S_ADD3,
    S_NND1, S_NND2, S_NND3,
    S_ADI1, S_ADI2, S_ADI3,
    S_LW1, S_LW2, S_LW3, S_LW4,
    S_SW1, S_SW2, S_SW3, S_SW4,
    S_BQ1, S_BQ2, S_BQ3, S_BQ4, S_BQ5, S_BQ6, S_BQ7,
    S_JR1, S_JR2,
    S_HALT
  } state_e;

  typedef struct packed {
    logic              dr_pc;
    logic              dr_alu;
    logic              dr_reg;
    logic              dr_mem;
    logic              dr_off;
    logic              ld_pc;
    logic              ld_ir;
    logic              ld_mar;
    logic              ld_a;
    logic              ld_b;
    logic              ld_z;
    logic              wr_reg;
    logic              wr_mem;
    logic [SEL_W-1:0]  reg_sel;
    logic [FUNC_W-1:0] alu_func;
  } ctl_word_t;
endpackage

// File: rtl/ctl_next_state.sv
module ctl_next_state
  import ctl_pkg::*;
(
  input  state_e           state_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             zero_i,
  output state_e           next_o
);
  always_comb begin
    next_o = S_F1;
    unique case (state_i)
      S_F1:   next_o = S_F2;
      S_F2:   next_o = S_F3;
      S_F3:   next_o = S_DEC;
      S_DEC: begin
        case (opcode_i)
          OP_ADD:  next_o = S_ADD1;
          OP_NAND: next_o = S_NND1;
          OP_ADDI: next_o = S_ADI1;
          OP_LW:   next_o = S_LW1;
          OP_SW:   next_o = S_SW1;
          OP_BEQ:  next_o = S_BQ1;
          OP_JALR: next_o = S_JR1;
          OP_HALT: next_o = S_HALT;
          default: next_o = S_F1;
        endcase
      end
      S_ADD1: next_o = S_ADD2;
      S_ADD2: next_o = S_ADD3;
      S_NND1: next_o = S_NND2;
      S_NND2: next_o = S_NND3;
      S_ADI1: next_o = S_ADI2;
      S_ADI2: next_o = S_ADI3;
      S_LW1:  next_o = S_LW2;
      S_LW2:  next_o = S_LW3;
      S_LW3:  next_o = S_LW4;
      S_SW1:  next_o = S_SW2;
      S_SW2:  next_o = S_SW3;
      S_SW3:  next_o = S_SW4;
      S_BQ1:  next_o = S_BQ2;
      S_BQ2:  next_o = S_BQ3;
      S_BQ3:  next_o = S_BQ4;
      // flag was loaded at the end of BQ3, test it here
      S_BQ4:  next_o = zero_i ? S_BQ5 : S_F1;
      S_BQ5:  next_o = S_BQ6;
      S_BQ6:  next_o = S_BQ7;
      S_JR1:  next_o = S_JR2;
      S_HALT: next_o = S_HALT;
      default: next_o = S_F1;
    endcase
  end
endmodule

// File: rtl/ctl_word_gen.sv
module ctl_word_gen
  import ctl_pkg::*;
(
  input  state_e    state_i,
  output ctl_word_t word_o
);
  always_comb begin
    word_o = '0;
    case (state_i)
      S_F1: begin word_o.dr_pc = 1'b1; word_o.ld_mar = 1'b1; word_o.ld_a = 1'b1; end
      S_F2: begin word_o.dr_mem = 1'b1; word_o.ld_ir = 1'b1; end
      S_F3: begin word_o.alu_func = FN_INC; word_o.dr_alu = 1'b1; word_o.ld_pc = 1'b1; end
      S_ADD1, S_NND1, S_ADI1, S_LW1, S_SW1, S_BQ1: begin
        word_o.reg_sel = SEL_SR1; word_o.dr_reg = 1'b1; word_o.ld_a = 1'b1;
      end
      S_ADD2, S_NND2, S_BQ2: begin
        word_o.reg_sel = SEL_SR2; word_o.dr_reg = 1'b1; word_o.ld_b = 1'b1;
      end
      S_ADI2, S_LW2, S_SW2, S_BQ6: begin word_o.dr_off = 1'b1; word_o.ld_b = 1'b1; end
      S_ADD3, S_NND3, S_ADI3: begin
        word_o.alu_func = (state_i == S_NND3) ? FN_NAND : FN_ADD;
        word_o.dr_alu   = 1'b1;
        word_o.reg_sel  = SEL_DST;
        word_o.wr_reg   = 1'b1;
      end
      S_LW3, S_SW3: begin word_o.alu_func = FN_ADD; word_o.dr_alu = 1'b1; word_o.ld_mar = 1'b1; end
      S_LW4: begin word_o.dr_mem = 1'b1; word_o.reg_sel = SEL_DST; word_o.wr_reg = 1'b1; end
      S_SW4: begin word_o.dr_reg = 1'b1; word_o.reg_sel = SEL_DST; word_o.wr_mem = 1'b1; end
      S_BQ3: begin word_o.alu_func = FN_SUB; word_o.dr_alu = 1'b1; word_o.ld_z = 1'b1; end
      S_BQ5: begin word_o.dr_pc = 1'b1; word_o.ld_a = 1'b1; end
      S_BQ7: begin word_o.alu_func = FN_ADD; word_o.dr_alu = 1'b1; word_o.ld_pc = 1'b1; end
      S_JR1: begin word_o.dr_pc = 1'b1; word_o.reg_sel = SEL_SR1; word_o.wr_reg = 1'b1; end
      S_JR2: begin word_o.reg_sel = SEL_DST; word_o.dr_reg = 1'b1; word_o.ld_pc = 1'b1; end
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              zero_i,
  output logic              dr_pc_o,
  output logic              dr_alu_o,
  output logic              dr_reg_o,
  output logic              dr_mem_o,
  output logic              dr_off_o,
  output logic              ld_pc_o,
  output logic              ld_ir_o,
  output logic              ld_mar_o,
  output logic              ld_a_o,
  output logic              ld_b_o,
  output logic              ld_z_o,
  output logic              wr_reg_o,
  output logic              wr_mem_o,
  output logic [SEL_W-1:0]  reg_sel_o,
  output logic [FUNC_W-1:0] alu_func_o
);
  state_e    state_q, state_d;
  ctl_word_t word, word_g;

  ctl_next_state u_next (
    .state_i  (state_q),
    .opcode_i (opcode_i),
    .zero_i   (zero_i),
    .next_o   (state_d)
  );

  ctl_word_gen u_word (
    .state_i (state_q),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_F1;
    else         state_q <= state_d;
  end

  // all enables quiet while reset is held
  assign word_g = rst_ni ? word : '0;

  assign dr_pc_o    = word_g.dr_pc;
  assign dr_alu_o   = word_g.dr_alu;
  assign dr_reg_o   = word_g.dr_reg;
  assign dr_mem_o   = word_g.dr_mem;
  assign dr_off_o   = word_g.dr_off;
  assign ld_pc_o    = word_g.ld_pc;
  assign ld_ir_o    = word_g.ld_ir;
  assign ld_mar_o   = word_g.ld_mar;
  assign ld_a_o     = word_g.ld_a;
  assign ld_b_o     = word_g.ld_b;
  assign ld_z_o     = word_g.ld_z;
  assign wr_reg_o   = word_g.wr_reg;
  assign wr_mem_o   = word_g.wr_mem;
  assign reg_sel_o  = word_g.reg_sel;
  assign alu_func_o = word_g.alu_func;
endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk
  import ctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dr_pc_o,
  input logic              dr_alu_o,
  input logic              dr_reg_o,
  input logic              dr_mem_o,
  input logic              dr_off_o,
  input logic              ld_pc_o,
  input logic              ld_ir_o,
  input logic              ld_mar_o,
  input logic              ld_a_o,
  input logic              ld_b_o,
  input logic              ld_z_o,
  input logic              wr_reg_o,
  input logic              wr_mem_o,
  input logic [SEL_W-1:0]  reg_sel_o,
  input logic [FUNC_W-1:0] alu_func_o
);
  logic quiet;
  assign quiet = !(dr_pc_o || dr_alu_o || dr_reg_o || dr_mem_o || dr_off_o ||
                   ld_pc_o || ld_ir_o || ld_mar_o || ld_a_o || ld_b_o ||
                   ld_z_o || wr_reg_o || wr_mem_o);

  // R12
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dr_pc_o, dr_alu_o, dr_reg_o, dr_mem_o, dr_off_o}));

  // R2
  fetch_step2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_pc_o && ld_mar_o && ld_a_o) |=> (dr_mem_o && ld_ir_o));

  // R2
  fetch_step3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ir_o |=> (dr_alu_o && ld_pc_o && alu_func_o == 2'd3));

  // R3
  decode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_pc_o && dr_alu_o && alu_func_o == 2'd3) |=> quiet);

  // R8
  flag_test_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_z_o |=> quiet);

  // R7
  store_then_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mem_o |=> (dr_pc_o && ld_mar_o && ld_a_o));

  // R9
  jalr_step2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_pc_o && wr_reg_o) |=> (dr_reg_o && ld_pc_o && reg_sel_o == 2'd0));
endmodule

bind ctl_sequencer ctl_sequencer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dr_pc_o    (dr_pc_o),
  .dr_alu_o   (dr_alu_o),
  .dr_reg_o   (dr_reg_o),
  .dr_mem_o   (dr_mem_o),
  .dr_off_o   (dr_off_o),
  .ld_pc_o    (ld_pc_o),
  .ld_ir_o    (ld_ir_o),
  .ld_mar_o   (ld_mar_o),
  .ld_a_o     (ld_a_o),
  .ld_b_o     (ld_b_o),
  .ld_z_o     (ld_z_o),
  .wr_reg_o   (wr_reg_o),
  .wr_mem_o   (wr_mem_o),
  .reg_sel_o  (reg_sel_o),
  .alu_func_o (alu_func_o)
);

// File: tb/tb_ctl_sequencer.sv
module tb_ctl_sequencer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] opcode_i = 4'd0;
  logic       zero_i = 1'b0;
  logic dr_pc_o, dr_alu_o, dr_reg_o, dr_mem_o, dr_off_o;
  logic ld_pc_o, ld_ir_o, ld_mar_o, ld_a_o, ld_b_o, ld_z_o, wr_reg_o, wr_mem_o;
  logic [1:0] reg_sel_o, alu_func_o;
  logic [16:0] got;

  int checks = 0;
  int errors = 0;

  localparam int B_DRPC = 16, B_DRALU = 15, B_DRREG = 14, B_DRMEM = 13, B_DROFF = 12;
  localparam int B_LDPC = 11, B_LDIR = 10, B_LDMAR = 9, B_LDA = 8, B_LDB = 7;
  localparam int B_LDZ = 6, B_WRREG = 5, B_WRMEM = 4;

  always #2 clk_i = ~clk_i;

  ctl_sequencer dut (
    .clk_i, .rst_ni, .opcode_i, .zero_i,
    .dr_pc_o, .dr_alu_o, .dr_reg_o, .dr_mem_o, .dr_off_o,
    .ld_pc_o, .ld_ir_o, .ld_mar_o, .ld_a_o, .ld_b_o, .ld_z_o,
    .wr_reg_o, .wr_mem_o, .reg_sel_o, .alu_func_o
  );

  assign got = {dr_pc_o, dr_alu_o, dr_reg_o, dr_mem_o, dr_off_o, ld_pc_o, ld_ir_o,
                ld_mar_o, ld_a_o, ld_b_o, ld_z_o, wr_reg_o, wr_mem_o, reg_sel_o, alu_func_o};

  function automatic logic [16:0] exp_word(input int op, input int idx, input bit z);
    logic [16:0] e;
    int k;
    e = '0;
    k = idx - 4;
    if (idx == 0) begin e[B_DRPC] = 1; e[B_LDMAR] = 1; e[B_LDA] = 1; end
    else if (idx == 1) begin e[B_DRMEM] = 1; e[B_LDIR] = 1; end
    else if (idx == 2) begin e[1:0] = 2'd3; e[B_DRALU] = 1; e[B_LDPC] = 1; end
    else if (idx >= 4) begin
      case (op)
        0, 1: case (k)
          0: begin e[3:2] = 2'd1; e[B_DRREG] = 1; e[B_LDA] = 1; end
          1: begin e[3:2] = 2'd2; e[B_DRREG] = 1; e[B_LDB] = 1; end
          2: begin e[1:0] = 2'(op); e[B_DRALU] = 1; e[B_WRREG] = 1; end
          default: ;
        endcase
        2, 3, 4: case (k)
          0: begin e[3:2] = 2'd1; e[B_DRREG] = 1; e[B_LDA] = 1; end
          1: begin e[B_DROFF] = 1; e[B_LDB] = 1; end
          2: begin
            e[B_DRALU] = 1;
            if (op == 2) e[B_WRREG] = 1; else e[B_LDMAR] = 1;
          end
          3: begin
            if (op == 3) begin e[B_DRMEM] = 1; e[B_WRREG] = 1; end
            if (op == 4) begin e[B_DRREG] = 1; e[B_WRMEM] = 1; end
          end
          default: ;
        endcase
        5: case (k)
          0: begin e[3:2] = 2'd1; e[B_DRREG] = 1; e[B_LDA] = 1; end
          1: begin e[3:2] = 2'd2; e[B_DRREG] = 1; e[B_LDB] = 1; end
          2: begin e[1:0] = 2'd2; e[B_DRALU] = 1; e[B_LDZ] = 1; end
          4: begin e[B_DRPC] = 1; e[B_LDA] = 1; end
          5: begin e[B_DROFF] = 1; e[B_LDB] = 1; end
          6: begin e[B_DRALU] = 1; e[B_LDPC] = 1; end
          default: ;
        endcase
        6: case (k)
          0: begin e[B_DRPC] = 1; e[3:2] = 2'd1; e[B_WRREG] = 1; end
          1: begin e[B_DRREG] = 1; e[B_LDPC] = 1; end
          default: ;
        endcase
        default: ;
      endcase
    end
    return e;
  endfunction

  function automatic int exp_len(input int op, input bit z);
    case (op)
      0, 1, 2: return 7;
      3, 4:    return 8;
      5:       return z ? 11 : 8;
      6:       return 6;
      default: return 4;
    endcase
  endfunction

  function automatic string req_of(input int op, input int idx);
    if (idx < 3)  return "R2";
    if (idx == 3) return "R3";
    case (op)
      0, 1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_word(input logic [16:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
    // R12: single bus, at most one driver
    checks++;
    if ($countones(got[16:12]) > 1) begin
      errors++;
      $display("FAIL R12: drivers %05b expected at most one", got[16:12]);
    end
  endtask

  task automatic run_instr(input int op, input bit z);
    opcode_i = 4'(op);
    zero_i = z;
    for (int i = 0; i < exp_len(op, z); i++) begin
      check_word(exp_word(op, i, z), req_of(op, i));
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    check_word('0, "R1");
    @(negedge clk_i);
    check_word('0, "R1");
    rst_ni = 1'b1;
    #0;
    // R1: first fetch word right after release
    check_word(exp_word(0, 0, 1'b0), "R1");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int op;
    seed = 32'h5eed_c7a1;
    void'($urandom(seed));
    @(negedge clk_i);
    check_word('0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0;
    check_word(exp_word(0, 0, 1'b0), "R1");

    // directed: each opcode, beq both ways, undefined
    for (int o = 0; o < 7; o++) run_instr(o, 1'b0);
    run_instr(5, 1'b1);
    run_instr(9, 1'b1);
    run_instr(15, 1'b0);

    // R10: halt parks with quiet words
    opcode_i = 4'd7;
    for (int i = 0; i < 16; i++) begin
      check_word(exp_word(7, i, 1'b0), req_of(7, i));
      if (i == 4) opcode_i = 4'd0;
      @(negedge clk_i);
    end
    do_reset();

    // random mix
    for (int n = 0; n < 600; n++) begin
      op = int'($urandom_range(0, 15));
      if (op == 7) op = 5;
      run_instr(op, 1'($urandom_range(0, 1)));
      if (n % 150 == 149) begin
        opcode_i = 4'd7;
        for (int i = 0; i < 8; i++) begin
          check_word(exp_word(7, i, 1'b0), req_of(7, i));
          @(negedge clk_i);
        end
        do_reset();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule